// File: doc/BRIEF.md
# Management PHY Register Responder

This block stands in for the register file of an Ethernet PHY as seen through a management port. Software reaches it through a small word-addressed register bus. The bus has four words: a command word, a data word, an interrupt-status word and an interrupt-enable word. Writing the command word names a PHY address, a register number and a direction.

One clock later the block executes the command, but only if the PHY address matches the `phy_addr_i` strap. A write copies the data word into the addressed PHY register. A read loads the data word with that register's value.

The PHY side holds a writable control register and a writable advertisement register. It also holds a status register built from fixed ability bits plus the live link state, two fixed identifier registers and a fixed link-partner register. An interrupt line reports completed commands and link changes through a write-one-to-clear status word and an enable mask. The current control and status words are also driven out directly.

Top module: `mgmt_phy_responder`

## Requirements
- R1: A bus write to the command word (bus address 0) stores all 32 bits of the written value with bit 0 (busy) forced to 0. The stored word reads back at bus address 0. Its fields are PHY address [15:12], register number [7:4] and direction bit 1 (1 = write into the PHY register).
- R2: A command whose PHY address field differs from `phy_addr_i` leaves the control, advertisement and data words unchanged and does not raise the command-done interrupt bit.
- R3: After reset, control reads 0x3100, advertisement 0, the command and data words 0, interrupt status and enable 0, and `irq_o` is low.
- R4: A command write to PHY register 0 with data bit 15 set returns control to 0x3100 and advertisement to 0, while the status link bit keeps following the link input.
- R5: Any other command write to PHY register 0 stores the data word with bits 15 and 9 forced to 0.
- R6: PHY register 1 and `status_o` read 0xFE28 with bit 2 set when the link is up (0xFE2C). Bit 2 reflects `link_up_i` one clock after it changes, whatever the command traffic.
- R7: PHY registers 2 and 3 read 0x0044 and 0x1400, and register 5 reads 0x0DE0.
- R8: Command writes to PHY registers 1, 2, 3, 5 and any register number above 5 change nothing. A command read of any register number above 5 loads 0 into the data word.
- R9: A command executes on the clock edge after the one that stores it. A read of the data word between those two edges still shows the old value, and a read after the second edge shows the new one. When both happen on the same edge, a loading command read wins over a bus write to the data word (bus address 1).
- R10: Interrupt status (bus address 2) has bit 0 = command executed for this PHY and bit 1 = link input changed. A bus write to it clears every bit that is set in the written value, and a new event on the same edge wins over the clear. `irq_o` is high when any bit of status AND enable (bus address 3) is set.
- R11: The advertisement register (PHY register 4) stores the data word on a command write and returns it on a command read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_i | input | 4 | PHY address this responder answers to |
| link_up_i | input | 1 | Link state from the line side |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 2 | Bus word address: 0 command, 1 data, 2 interrupt status, 3 interrupt enable |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 16 | Current PHY control register |
| status_o | output | 16 | Current PHY status register |

## Verification
A wrong control or advertisement value stays hidden until a command read copies it into the data word. It therefore shows at the bus two edges after the command write. `ctrl_o` exposes the control register one edge after the faulty command. A fault in the link sampler or in event capture reaches `status_o` and `irq_o` on the next edge. A command that executes on the wrong edge, or for the wrong PHY address, shows up as a data word that changes one cycle early, late or not at all. The bench therefore compares every output against a behavioural model on every cycle, as well as making directed checks.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int PHY_AW    = 4;
  localparam int REG_AW    = 4;
  localparam int PHY_DW    = 16;
  localparam int BUS_DW    = 32;
  localparam int BUS_AW    = 2;
  localparam int IRQ_W     = 2;
  localparam int LINK_BIT  = 2;

  // PHY register numbers
  localparam logic [REG_AW-1:0] PREG_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] PREG_STAT    = 4'd1;
  localparam logic [REG_AW-1:0] PREG_ID_HI   = 4'd2;
  localparam logic [REG_AW-1:0] PREG_ID_LO   = 4'd3;
  localparam logic [REG_AW-1:0] PREG_ADV     = 4'd4;
  localparam logic [REG_AW-1:0] PREG_PARTNER = 4'd5;

  // fixed values
  localparam logic [PHY_DW-1:0] CTRL_RESET   = 16'h3100;
  localparam logic [PHY_DW-1:0] STATUS_BASE  = 16'hFE28;
  localparam logic [PHY_DW-1:0] ID_HI_VAL    = 16'h0044;
  localparam logic [PHY_DW-1:0] ID_LO_VAL    = 16'h1400;
  localparam logic [PHY_DW-1:0] PARTNER_VAL  = 16'h0DE0;
  localparam int                CTRL_SOFTRST = 15;
  localparam int                CTRL_RESTART = 9;

  // bus words
  typedef enum logic [BUS_AW-1:0] {
    BW_CMD  = 2'd0,
    BW_DATA = 2'd1,
    BW_ISTA = 2'd2,
    BW_IEN  = 2'd3
  } bus_word_e;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regn;
    logic              wr;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [BUS_DW-1:0] w);
    cmd_t c;
    c.phy  = w[15:12];
    c.regn = w[7:4];
    c.wr   = w[1];
    return c;
  endfunction

  function automatic logic [PHY_DW-1:0] ctrl_masked(input logic [PHY_DW-1:0] d);
    logic [PHY_DW-1:0] m;
    m = d;
    m[CTRL_SOFTRST] = 1'b0;
    m[CTRL_RESTART] = 1'b0;
    return m;
  endfunction

  function automatic logic [PHY_DW-1:0] status_word(input logic link);
    logic [PHY_DW-1:0] s;
    s = STATUS_BASE;
    s[LINK_BIT] = link;
    return s;
  endfunction

  function automatic logic [PHY_DW-1:0] phy_read(input logic [REG_AW-1:0] r,
                                                 input logic [PHY_DW-1:0] ctrl,
                                                 input logic [PHY_DW-1:0] adv,
                                                 input logic              link);
    logic [PHY_DW-1:0] v;
    case (r)
      PREG_CTRL:    v = ctrl;
      PREG_STAT:    v = status_word(link);
      PREG_ID_HI:   v = ID_HI_VAL;
      PREG_ID_LO:   v = ID_LO_VAL;
      PREG_ADV:     v = adv;
      PREG_PARTNER: v = PARTNER_VAL;
      default:      v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mgmt_phy_cmd_port.sv
module mgmt_phy_cmd_port
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic [BUS_DW-1:0] cmd_wdata_i,
  output logic [BUS_DW-1:0] cmd_word_o,
  output logic              exec_o,
  output cmd_t              cmd_o
);

  logic [BUS_DW-1:0] cmd_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= cmd_wr_i;
      if (cmd_wr_i) begin
        cmd_q    <= cmd_wdata_i;
        cmd_q[0] <= 1'b0;
      end
    end
  end

  assign cmd_word_o = cmd_q;
  assign exec_o     = pend_q;
  assign cmd_o      = cmd_decode(cmd_q);

  // R9: a stored command executes on the next edge, exactly once
  p_exec_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_i |=> exec_o);
  p_exec_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_i |=> !exec_o);
  // R1: stored word never shows busy after a command write
  p_busy_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_i |=> (cmd_word_o[0] == 1'b0) && (cmd_word_o[BUS_DW-1:1] == $past(cmd_wdata_i[BUS_DW-1:1])));

endmodule

// File: rtl/mgmt_phy_core.sv
module mgmt_phy_core
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  cmd_t              cmd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic              link_i,
  input  logic              data_wr_i,
  input  logic [PHY_DW-1:0] data_wdata_i,
  output logic [PHY_DW-1:0] data_o,
  output logic [PHY_DW-1:0] ctrl_o,
  output logic [PHY_DW-1:0] adv_o,
  output logic              hit_o
);

  logic [PHY_DW-1:0] ctrl_q, adv_q, data_q, rd_val;
  logic hit, wr_ctrl, soft_rst, wr_adv, ld_data;

  assign hit      = exec_i && (cmd_i.phy == phy_addr_i);
  assign rd_val   = phy_read(cmd_i.regn, ctrl_q, adv_q, link_i);
  assign wr_ctrl  = hit && cmd_i.wr && (cmd_i.regn == PREG_CTRL);
  assign soft_rst = wr_ctrl && data_q[CTRL_SOFTRST];
  assign wr_adv   = hit && cmd_i.wr && (cmd_i.regn == PREG_ADV);
  assign ld_data  = hit && !cmd_i.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      adv_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_RESET;
      adv_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_masked(data_q);
      if (wr_adv)  adv_q  <= data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (ld_data)   data_q <= rd_val;
    else if (data_wr_i) data_q <= data_wdata_i;
  end

  assign data_o = data_q;
  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;
  assign hit_o  = hit;

  // R2: a command for another PHY changes nothing
  p_addr_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !hit && !data_wr_i) |=> ($stable(ctrl_o) && $stable(adv_o) && $stable(data_o)));
  // R4: soft reset returns writable registers to reset values
  p_soft_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_o == CTRL_RESET) && (adv_o == '0));
  // R5: control write drops bits 15 and 9, keeps the rest
  p_ctrl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !data_q[CTRL_SOFTRST]) |=>
      !ctrl_o[CTRL_SOFTRST] && !ctrl_o[CTRL_RESTART] && (ctrl_o[14:10] == $past(data_o[14:10])));
  // R8: writes to fixed or unknown registers leave state alone
  p_ro_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd_i.wr && (cmd_i.regn != PREG_CTRL) && (cmd_i.regn != PREG_ADV)) |=>
      ($stable(ctrl_o) && $stable(adv_o)));

endmodule

// File: rtl/mgmt_phy_irq.sv
module mgmt_phy_irq
  import mgmt_phy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic             en_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] sta_o,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);

  logic [IRQ_W-1:0] sta_q, en_q, clr_mask;

  assign clr_mask = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      en_q  <= '0;
    end else begin
      sta_q <= (sta_q & ~clr_mask) | set_i;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign sta_o = sta_q;
  assign en_o  = en_q;
  assign irq_o = |(sta_q & en_q);

  // R10: write-one-to-clear empties the named bits when nothing new arrives
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && (set_i == '0)) |=> ((sta_o & $past(wdata_i)) == '0));
  // R10: an event is always captured, even against a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((sta_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic              link_up_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic [PHY_DW-1:0] ctrl_o,
  output logic [PHY_DW-1:0] status_o
);

  logic              link_q, link_evt, hit;
  logic              wr_cmd, wr_data, wr_ista, wr_ien, exec;
  logic [BUS_DW-1:0] cmd_word;
  logic [PHY_DW-1:0] data_w, adv_w;
  logic [IRQ_W-1:0]  ista_w, ien_w;
  cmd_t              cmd;

  assign wr_cmd  = bus_wr_i && (bus_addr_i == BW_CMD);
  assign wr_data = bus_wr_i && (bus_addr_i == BW_DATA);
  assign wr_ista = bus_wr_i && (bus_addr_i == BW_ISTA);
  assign wr_ien  = bus_wr_i && (bus_addr_i == BW_IEN);

  // link sampler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up_i;
  end
  assign link_evt = link_q ^ link_up_i;

  mgmt_phy_cmd_port u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (wr_cmd),
    .cmd_wdata_i (bus_wdata_i),
    .cmd_word_o  (cmd_word),
    .exec_o      (exec),
    .cmd_o       (cmd)
  );

  mgmt_phy_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec),
    .cmd_i        (cmd),
    .phy_addr_i   (phy_addr_i),
    .link_i       (link_q),
    .data_wr_i    (wr_data),
    .data_wdata_i (bus_wdata_i[PHY_DW-1:0]),
    .data_o       (data_w),
    .ctrl_o       (ctrl_o),
    .adv_o        (adv_w),
    .hit_o        (hit)
  );

  mgmt_phy_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    ({link_evt, hit}),
    .clr_wr_i (wr_ista),
    .en_wr_i  (wr_ien),
    .wdata_i  (bus_wdata_i[IRQ_W-1:0]),
    .sta_o    (ista_w),
    .en_o     (ien_w),
    .irq_o    (irq_o)
  );

  assign status_o = status_word(link_q);

  always_comb begin
    case (bus_addr_i)
      BW_CMD:  bus_rdata_o = cmd_word;
      BW_DATA: bus_rdata_o = {{(BUS_DW-PHY_DW){1'b0}}, data_w};
      BW_ISTA: bus_rdata_o = {{(BUS_DW-IRQ_W){1'b0}}, ista_w};
      default: bus_rdata_o = {{(BUS_DW-IRQ_W){1'b0}}, ien_w};
    endcase
  end

  // R6: status link bit tracks the input one edge later
  p_link_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[LINK_BIT] == $past(link_up_i)));
  // R6: link bit stays put across a soft reset of the PHY registers (R4)
  p_link_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd.wr && (cmd.regn == PREG_CTRL) && (link_q == link_up_i)) |=>
      $stable(status_o));

endmodule

// File: tb/mgmt_phy_responder_tb.sv
`timescale 1ns/1ps
module mgmt_phy_responder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  phy_addr = 4'd0;
  logic        link = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [15:0] ctrl, status;

  int tests = 0;
  int fails = 0;
  bit live  = 1'b0;

  always #2.5 clk = ~clk;

  mgmt_phy_responder u_dut (
    .clk(clk), .rst_n(rst_n), .phy_addr_i(phy_addr), .link_up_i(link),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .ctrl_o(ctrl), .status_o(status)
  );

  // behavioural reference model
  logic [31:0] m_cmd;
  logic        m_pend, m_link;
  logic [15:0] m_data, m_ctrl, m_adv;
  logic [1:0]  m_ista, m_ien;

  function automatic logic [15:0] ref_reg(int r, logic [15:0] c, logic [15:0] a, logic l);
    if (r == 0) return c;
    if (r == 1) return l ? 16'hFE2C : 16'hFE28;
    if (r == 2) return 16'h0044;
    if (r == 3) return 16'h1400;
    if (r == 4) return a;
    if (r == 5) return 16'h0DE0;
    return 16'h0000;
  endfunction

  function automatic logic [31:0] ref_bus(int a);
    if (a == 0) return m_cmd;
    if (a == 1) return {16'h0, m_data};
    if (a == 2) return {30'h0, m_ista};
    return {30'h0, m_ien};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_pend = 0; m_link = 0; m_data = 0;
      m_ctrl = 16'h3100; m_adv = 0; m_ista = 0; m_ien = 0;
    end else begin
      logic [15:0] nd, nc, na;
      logic [1:0]  ns;
      int r;
      nd = m_data; nc = m_ctrl; na = m_adv; ns = m_ista;
      if (bus_wr && bus_addr == 1) nd = bus_wdata[15:0];
      if (bus_wr && bus_addr == 2) ns = ns & ~bus_wdata[1:0];
      if (m_pend && m_cmd[15:12] == phy_addr) begin
        r = int'(m_cmd[7:4]);
        if (m_cmd[1]) begin
          if (r == 0) begin
            if (m_data[15]) begin nc = 16'h3100; na = 0; end
            else nc = m_data & 16'h7DFF;
          end else if (r == 4) na = m_data;
        end else nd = ref_reg(r, m_ctrl, m_adv, m_link);
        ns[0] = 1'b1;
      end
      if (link != m_link) ns[1] = 1'b1;
      if (bus_wr && bus_addr == 3) m_ien = bus_wdata[1:0];
      m_pend = bus_wr && bus_addr == 0;
      if (m_pend) m_cmd = bus_wdata & 32'hFFFF_FFFE;
      m_link = link; m_data = nd; m_ctrl = nc; m_adv = na; m_ista = ns;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock; compare against the model away from the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    if (live) begin
      chk("R9 model ctrl", {16'h0, ctrl}, {16'h0, m_ctrl});
      chk("R6 model status", {16'h0, status}, {16'h0, (m_link ? 16'hFE2C : 16'hFE28)});
      chk("R10 model irq", {31'h0, irq}, {31'h0, |(m_ista & m_ien)});
      chk("R9 model rdata", bus_rdata, ref_bus(int'(bus_addr)));
    end
  endtask

  task automatic bw(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // command word: phy [15:12], reg [7:4], write bit 1, busy bit 0 set on purpose
  function automatic logic [31:0] cw(logic [3:0] p, logic [3:0] r, logic w);
    return {16'h0, p, 4'h0, r, 2'b00, w, 1'b1};
  endfunction

  task automatic phy_rd(logic [3:0] p, logic [3:0] r);
    bw(2'd0, cw(p, r, 1'b0));
    tick();
  endtask

  task automatic phy_wr(logic [3:0] p, logic [3:0] r, logic [15:0] d);
    bw(2'd1, {16'h0, d});
    bw(2'd0, cw(p, r, 1'b1));
    tick();
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3 reset state
    chk("R3 ctrl", {16'h0, ctrl}, 32'h3100);
    chk("R3 status", {16'h0, status}, 32'hFE28);
    chk("R3 irq", {31'h0, irq}, 32'h0);
    rd("R3 cmd", 2'd0, 32'h0);
    rd("R3 data", 2'd1, 32'h0);
    rd("R3 ista", 2'd2, 32'h0);
    live = 1'b1;
    tick();

    // R1 busy cleared on store; R3 adv reset value
    bw(2'd0, cw(4'd0, 4'd4, 1'b0));
    rd("R1 busy cleared", 2'd0, 32'h0000_0040);
    tick();
    rd("R3 adv reset", 2'd1, 32'h0);

    // R7 fixed registers
    phy_rd(4'd0, 4'd2); rd("R7 id hi", 2'd1, 32'h0044);
    phy_rd(4'd0, 4'd3); rd("R7 id lo", 2'd1, 32'h1400);
    phy_rd(4'd0, 4'd5); rd("R7 partner", 2'd1, 32'h0DE0);

    // R6 status and link tracking
    phy_rd(4'd0, 4'd1); rd("R6 status down", 2'd1, 32'hFE28);
    link = 1'b1;
    tick();
    chk("R6 link up one clock", {16'h0, status}, 32'hFE2C);
    phy_rd(4'd0, 4'd1); rd("R6 status up", 2'd1, 32'hFE2C);

    // R11 advertisement
    phy_wr(4'd0, 4'd4, 16'h05E1);
    phy_rd(4'd0, 4'd4); rd("R11 adv readback", 2'd1, 32'h05E1);

    // R5 control masking
    phy_wr(4'd0, 4'd0, 16'h7FFF);
    chk("R5 mask", {16'h0, ctrl}, 32'h7DFF);
    phy_wr(4'd0, 4'd0, 16'h0200);
    chk("R5 restart only", {16'h0, ctrl}, 32'h0000);

    // R4 soft reset keeps link
    phy_wr(4'd0, 4'd0, 16'h8000);
    chk("R4 ctrl reset", {16'h0, ctrl}, 32'h3100);
    chk("R4 link kept", {16'h0, status}, 32'hFE2C);
    phy_rd(4'd0, 4'd4); rd("R4 adv reset", 2'd1, 32'h0);

    // R8 fixed registers ignore writes; unknown read is 0
    phy_wr(4'd0, 4'd2, 16'h1234);
    phy_wr(4'd0, 4'd9, 16'h5555);
    chk("R8 ctrl untouched", {16'h0, ctrl}, 32'h3100);
    phy_rd(4'd0, 4'd2); rd("R8 id kept", 2'd1, 32'h0044);
    phy_rd(4'd0, 4'd9); rd("R8 unknown zero", 2'd1, 32'h0);

    // R2 address mismatch
    phy_addr = 4'd3;
    bw(2'd2, 32'h3);
    bw(2'd1, 32'hABCD);
    bw(2'd0, cw(4'd0, 4'd2, 1'b0));
    tick();
    rd("R2 data kept", 2'd1, 32'hABCD);
    rd("R2 no done", 2'd2, 32'h0);
    bw(2'd0, cw(4'd0, 4'd0, 1'b1));
    tick();
    chk("R2 ctrl kept", {16'h0, ctrl}, 32'h3100);

    // R9 timing and priority
    bw(2'd0, cw(4'd3, 4'd3, 1'b0));
    rd("R9 old before exec", 2'd1, 32'hABCD);
    bw(2'd1, 32'h0F0F);
    rd("R9 read wins", 2'd1, 32'h1400);

    // R10 interrupts
    rd("R10 done set", 2'd2, 32'h1);
    bw(2'd3, 32'h1);
    chk("R10 irq on", {31'h0, irq}, 32'h1);
    bw(2'd2, 32'h1);
    chk("R10 cleared", {31'h0, irq}, 32'h0);
    link = 1'b0;
    tick();
    rd("R10 link event", 2'd2, 32'h2);
    chk("R10 masked", {31'h0, irq}, 32'h0);
    bw(2'd3, 32'h2);
    chk("R10 irq link", {31'h0, irq}, 32'h1);
    bus_addr = 2'd2; bus_wdata = 32'h2; bus_wr = 1'b1; link = 1'b1;
    tick();
    bus_wr = 1'b0;
    rd("R10 set beats clear", 2'd2, 32'h2);
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule